// File: doc/BRIEF.md
# Real-Time-Clock Interrupt / Square-Wave Pin Controller

This block owns one output pin of a real-time clock that can serve either as a rate-selectable square wave or as an active-low alarm interrupt. It holds the control byte that picks the pin's role, the square-wave rate and the alarm interrupt enables. It also holds the two alarm flags. It divides a 32.768 kHz oscillator tick down to four square-wave rates. It drives the pin as a value plus an output enable. An output enable of 0 means the pin is released (high impedance), which lets an external pull-up give the open-drain interrupt behaviour.

The alarm comparators deliver single-cycle match pulses. Each pulse sets its flag whatever the pin mode or enables are. Software clears a flag by writing 0 to its bit. When the clock runs from its backup battery, a separate control bit decides whether the square wave keeps being driven. The register port is byte wide: address 0 is the control byte and address 1 is the flag byte. Writes take effect at the clock edge and reads are combinational.

Top module: `rtc_irq_sqw_ctrl`

## Requirements
- R1: After reset the control byte reads 8'h1C, the flag byte reads 8'h00, and pin_oe is 0.
- R2: A write at address 0 stores all eight bits, and they read back unchanged. The bit meanings are: bit 7 oscillator stop on battery (stored only), bit 6 battery square-wave enable, bit 5 convert request (stored only), bits 4:3 rate, bit 2 mode (1 = interrupt, 0 = square wave), bit 1 alarm-2 interrupt enable, bit 0 alarm-1 interrupt enable.
- R3: In square-wave mode the half period in ticks is 16384 for rate 0 (1 Hz), 16 for rate 1 (1.024 kHz), 4 for rate 2 (4.096 kHz) and 2 for rate 3 (8.192 kHz). After n ticks from a restart, pin_val equals (n / half) mod 2.
- R4: A control write that changes the rate, or any cycle in interrupt mode, restarts the divider. The wave then reads 0, and its first edge comes a full new half period of ticks later.
- R5: The divider advances only in cycles with tick high. Between ticks pin_val holds.
- R6: An alarm-1 pulse sets flag bit 0 and an alarm-2 pulse sets flag bit 1 of the byte at address 1. This happens in every mode and for every enable setting.
- R7: A write at address 1 clears each flag whose data bit is 0 and leaves a flag alone where the data bit is 1. A match pulse in the same cycle as a clear leaves that flag set.
- R8: In interrupt mode the pin is driven low (pin_oe=1, pin_val=0) exactly when (flag1 and enable1) or (flag2 and enable2). Otherwise pin_oe is 0.
- R9: In square-wave mode on main power, pin_oe is 1 and pin_val is the divided wave, whatever the flags are.
- R10: On battery in square-wave mode, pin_oe equals the battery square-wave enable bit. Interrupt mode behaves the same on battery as on main power.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at 32.768 kHz |
| on_battery | input | 1 | High while running from backup supply |
| alarm1_hit | input | 1 | Alarm-1 match pulse |
| alarm2_hit | input | 1 | Alarm-2 match pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control byte, 1 = flag byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| pin_val | output | 1 | Value driven on the shared pin |
| pin_oe | output | 1 | Pin drive enable; 0 releases the pin |

## Verification
The embedded assertions check every cycle that the divider count stays within the current half period, that the wave holds between ticks, and that a match pulse always leaves its flag set. They also check that a flag write can only clear bits, that interrupt mode never drives the pin high, and that battery gating releases the pin. The bench scenarios cover the rest: the exact tick count of each rate and of a restart after a rate change, the whole table of enable, mode and flag combinations for the pin, and the reset contents of both bytes.

// File: rtl/sqwint_pkg.sv
package sqwint_pkg;

  typedef struct packed {
    logic       osc_stop;
    logic       batt_sqw;
    logic       conv_req;
    logic [1:0] rate;
    logic       irq_mode;
    logic       a2_en;
    logic       a1_en;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h1C;

  // Half period of the square wave, counted in oscillator ticks.
  function automatic int half_ticks(input logic [1:0] rate, input int osc_hz);
    case (rate)
      2'd0:    return osc_hz / 2;
      2'd1:    return osc_hz / 2048;
      2'd2:    return osc_hz / 8192;
      default: return osc_hz / 16384;
    endcase
  endfunction

endpackage

// File: rtl/sqw_divider.sv
module sqw_divider
  import sqwint_pkg::*;
#(
  parameter int OSC_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       sq
);
  localparam int CNT_W = $clog2(OSC_HZ / 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             sq_q;
  logic             wrap;

  always_comb begin
    lim  = CNT_W'(half_ticks(rate, OSC_HZ) - 1);
    wrap = tick && (cnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sq_q  <= ~sq_q;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sq = sq_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(sq_q));

  assert_restart_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (sq_q == 1'b0));

endmodule

// File: rtl/alarm_flags.sv
module alarm_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hit,
  input  logic       wr_flags,
  input  logic [1:0] wr_bits,
  output logic [1:0] flags
);
  logic [1:0] flags_q;
  logic [1:0] clr;

  always_comb clr = wr_flags ? ~wr_bits : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= 2'b00;
    else        flags_q <= hit | (flags_q & ~clr);
  end

  assign flags = flags_q;

  assert_hit_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != 2'b00) |=> ((flags_q & $past(hit)) == $past(hit)));

  assert_write_only_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && hit == 2'b00) |=> (flags_q == ($past(flags_q) & $past(wr_bits))));

endmodule

// File: rtl/pin_mux.sv
module pin_mux (
  input  logic       irq_mode,
  input  logic       batt_sqw,
  input  logic       on_battery,
  input  logic [1:0] flags,
  input  logic [1:0] irq_en,
  input  logic       sq,
  output logic       pin_val,
  output logic       pin_oe
);
  logic irq_active;

  always_comb begin
    irq_active = |(flags & irq_en);
    if (irq_mode) begin
      pin_oe  = irq_active;
      pin_val = 1'b0;
    end else begin
      pin_oe  = !on_battery || batt_sqw;
      pin_val = sq;
    end
  end

  always_comb begin
    if (irq_mode && pin_oe) assert_irq_low_R8: assert (pin_val == 1'b0);
    if (!irq_mode && on_battery && !batt_sqw) assert_batt_release_R10: assert (!pin_oe);
  end

endmodule

// File: rtl/rtc_irq_sqw_ctrl.sv
module rtc_irq_sqw_ctrl
  import sqwint_pkg::*;
#(
  parameter int OSC_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       on_battery,
  input  logic       alarm1_hit,
  input  logic       alarm2_hit,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       pin_val,
  output logic       pin_oe
);
  ctrl_t      ctrl_q;
  ctrl_t      ctrl_wr;
  logic       wr_ctrl;
  logic       wr_flags;
  logic       rate_change;
  logic       div_restart;
  logic       sq;
  logic [1:0] flags;

  always_comb begin
    ctrl_wr     = ctrl_t'(wdata);
    wr_ctrl     = wr_en && !addr;
    wr_flags    = wr_en && addr;
    rate_change = wr_ctrl && (ctrl_wr.rate != ctrl_q.rate);
    div_restart = rate_change || ctrl_q.irq_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RESET);
    else if (wr_ctrl) ctrl_q <= ctrl_wr;
  end

  sqw_divider #(.OSC_HZ(OSC_HZ)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (div_restart),
    .rate    (ctrl_q.rate),
    .sq      (sq)
  );

  alarm_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      ({alarm2_hit, alarm1_hit}),
    .wr_flags (wr_flags),
    .wr_bits  (wdata[1:0]),
    .flags    (flags)
  );

  pin_mux u_mux (
    .irq_mode   (ctrl_q.irq_mode),
    .batt_sqw   (ctrl_q.batt_sqw),
    .on_battery (on_battery),
    .flags      (flags),
    .irq_en     ({ctrl_q.a2_en, ctrl_q.a1_en}),
    .sq         (sq),
    .pin_val    (pin_val),
    .pin_oe     (pin_oe)
  );

  assign rdata = addr ? {6'b0, flags} : 8'(ctrl_q);

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (8'(ctrl_q) == $past(wdata)));

endmodule

// File: tb/tb_rtc_irq_sqw_ctrl.sv
module tb_rtc_irq_sqw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       on_battery = 1'b0;
  logic       alarm1_hit = 1'b0;
  logic       alarm2_hit = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pin_val;
  logic       pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rtc_irq_sqw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .on_battery(on_battery),
    .alarm1_hit(alarm1_hit), .alarm2_hit(alarm2_hit), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int half_of(input int r);
    return 32768 / (r == 0 ? 2 : (r == 1 ? 2048 : (r == 2 ? 8192 : 16384)));
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  // Applies n ticks after a restart, checking the wave after each.
  task automatic run_wave(input string req, input int half, input int start_n,
                          input int n, input bit gaps);
    for (int i = 1; i <= n; i++) begin
      if (gaps) begin
        tick = 1'b0;
        @(negedge clk); #1;
        chk(req, pin_val, ((start_n + i - 1) / half) % 2);
      end
      tick = 1'b1;
      @(negedge clk); #1;
      chk(req, pin_val, ((start_n + i) / half) % 2);
    end
    tick = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, d); chk("R1", d, 8'h1C);
    rd(1'b1, d); chk("R1", d, 8'h00);
    chk("R1", pin_oe, 0);

    // R2 readback across patterns
    for (int v = 0; v < 256; v += 37) begin
      wr(1'b0, 8'(v) | 8'h04);
      rd(1'b0, d); chk("R2", d, (v | 4) & 255);
    end

    // R3 each rate from a fresh start (mode 1 -> 0 restarts)
    for (int r = 0; r < 4; r++) begin
      wr(1'b0, 8'h04 | 8'(r << 3));
      wr(1'b0, 8'(r << 3));
      chk("R9", pin_oe, 1);
      run_wave("R3", half_of(r), 0, (r == 0) ? 2 * 16384 + 3 : 4 * half_of(r) + 1, 1'b0);
    end

    // R4 rate change mid-wave: rate 3, go high, then switch to rate 2
    wr(1'b0, 8'h1C);
    wr(1'b0, 8'h18);
    run_wave("R4", 2, 0, 3, 1'b0);
    chk("R4", pin_val, 1);
    wr(1'b0, 8'h10);
    chk("R4", pin_val, 0);
    run_wave("R4", 4, 0, 17, 1'b0);
    // same-rate write does not restart
    wr(1'b0, 8'h10);
    run_wave("R4", 4, 17, 6, 1'b0);

    // R5 ticks with idle cycles between them
    wr(1'b0, 8'h0C);
    wr(1'b0, 8'h08);
    run_wave("R5", 16, 0, 40, 1'b1);

    // R9 flags ignored in square mode on main power; R6 flags still set
    @(negedge clk); alarm1_hit = 1'b1; alarm2_hit = 1'b1;
    @(negedge clk); alarm1_hit = 1'b0; alarm2_hit = 1'b0;
    wr(1'b0, 8'h0B);
    chk("R9", pin_oe, 1);
    rd(1'b1, d); chk("R6", d, 8'h03);

    // R10 battery gating
    on_battery = 1'b1;
    wr(1'b0, 8'h0B); #1; chk("R10", pin_oe, 0);
    wr(1'b0, 8'h4B); #1; chk("R10", pin_oe, 1);
    wr(1'b0, 8'h07); #1; chk("R10", pin_oe, 1); chk("R10", pin_val, 0);
    on_battery = 1'b0;

    // R7 write ones has no effect, zeros clear
    wr(1'b1, 8'hFF); rd(1'b1, d); chk("R7", d, 8'h03);
    wr(1'b1, 8'hFE); rd(1'b1, d); chk("R7", d, 8'h02);
    wr(1'b1, 8'h00); rd(1'b1, d); chk("R7", d, 8'h00);
    // hit during clear wins
    @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'h00; alarm2_hit = 1'b1;
    @(negedge clk); wr_en = 1'b0; alarm2_hit = 1'b0;
    rd(1'b1, d); chk("R7", d, 8'h02);

    // R8 exhaustive over enables, flags and mode; R6 in every setting
    for (int c = 0; c < 32; c++) begin
      logic en1, en2, md, f1, f2;
      en1 = c[0]; en2 = c[1]; md = c[2]; f1 = c[3]; f2 = c[4];
      wr(1'b0, {5'b00011, md, en2, en1});
      wr(1'b1, 8'h00);
      @(negedge clk); alarm1_hit = f1; alarm2_hit = f2;
      @(negedge clk); alarm1_hit = 1'b0; alarm2_hit = 1'b0;
      rd(1'b1, d); chk("R6", d, {f2, f1});
      if (md) begin
        chk("R8", pin_oe, (f1 & en1) | (f2 & en2));
        if (pin_oe) chk("R8", pin_val, 0);
      end else begin
        chk("R9", pin_oe, 1);
      end
    end

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule